// File: doc/BRIEF.md
# Hex Text Record Memory Loader

This block turns a stream of ASCII characters into byte writes on a memory port. Characters arrive one per valid/ready handshake. The stream is a series of records, and each record normally spans two lines. The header line gives a start address and a byte count. The line that follows holds that many two-digit hex bytes. Each byte is written to the memory port at an address that starts from the header value and goes up by one for every byte.

A one-cycle `rec_done` pulse marks the end of each good record. Malformed numeric input sets a sticky `err` flag. The loader then throws away the rest of the faulty line and waits for a new header. It is meant to sit between a character source and a byte-wide RAM write port, so that a memory image can be loaded from plain text. Checksums and the memory array itself are outside the block.

Top module: `hexrec_loader`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ch_ready` is 1 and `wr_en`, `rec_done` and `err` are 0. Reset also abandons any partly received record.
- R2: Header format:
  - A header begins with exactly four hex digits of address.
  - A single space (0x20) follows the address.
  - The count follows as one or more hex digits and ends with a space.
  - Any text after that space, up to LF (0x0A), is ignored.
  - A fifth address digit is an error.
- R3: A data byte is two hex digits, high nibble first, and is committed only by the space that follows it. Bytes are written in stream order, the first to the header address and each later one to the previous address plus one.
- R4: Each write is a strobe on `wr_en` that lasts one cycle. In that cycle `wr_addr` and `wr_data` carry the byte and `ch_ready` is 0.
- R5: A count of zero gives no writes. `rec_done` pulses in the cycle after the header's LF is accepted, and no data line is expected.
- R6: For a nonzero count, `rec_done` is high for exactly one cycle, namely the cycle after the data line's LF is accepted.
- R7: The 16-bit write address wraps from 0xFFFF to 0x0000 without an error.
- R8: A CR (0x0D) is accepted and has no effect wherever it appears, including inside numeric fields.
- R9: After the N-th byte's trailing space, everything up to LF is ignored, including characters that look like hex.
- R10: Hex conversion and bad characters:
  - '0'..'9' (0x30..0x39) convert to 0..9.
  - 'A'..'F' (0x41..0x46) convert to 10..15.
  - In a numeric field, any other character sets `err` and causes no write. This covers the seven codes 0x3A..0x40, lowercase letters, and anything below 0x30 or above 0x46.
- R11: `err` stays set until reset. After a bad line, parsing resumes with a header once that line's LF has been accepted.
- R12: If a byte is followed by anything other than a space (LF included), `err` is set and that byte is not written. When the offending character is LF, it also ends the line.
- R13: An LF received before any header digit (a blank line) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_valid | input | 1 | Character present on `ch_data` |
| ch_data | input | 8 | ASCII character |
| ch_ready | output | 1 | Loader can take a character this cycle |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data |
| rec_done | output | 1 | One-cycle pulse at the end of a good record |
| err | output | 1 | Sticky malformed-input flag |

## Verification
An address register that has lost step shows up at the next write strobe as the wrong `wr_addr`. That strobe comes one cycle after the byte's trailing space is accepted. A sequencer in the wrong state shows as a strobe that is missing or extra, or as `rec_done` in a cycle other than the one after the LF. Either is visible within a line of input. A corrupted nibble path shows in `wr_data` on the same strobe. A classification fault shows as `err` rising, or failing to rise, one cycle after the offending character is accepted.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

  typedef enum logic [2:0] {
    CK_HEX,
    CK_GAP,
    CK_SPACE,
    CK_LF,
    CK_CR,
    CK_OTHER
  } chkind_t;

  typedef enum logic [3:0] {
    S_ADDR,
    S_CNT,
    S_HCMT,
    S_DHI,
    S_DLO,
    S_DSP,
    S_WR,
    S_DCMT,
    S_DROP
  } pstate_t;

  localparam logic [7:0] ASC_SPACE = 8'h20;
  localparam logic [7:0] ASC_LF    = 8'h0A;
  localparam logic [7:0] ASC_CR    = 8'h0D;
  localparam logic [7:0] ASC_ZERO  = 8'h30;
  localparam logic [7:0] ASC_BIGF  = 8'h46;

endpackage

// File: rtl/hexrec_charclass.sv
module hexrec_charclass
  import hexrec_pkg::*;
#(
  parameter int LUT_N = 32
) (
  input  logic [7:0] ch,
  output chkind_t    kind,
  output logic [3:0] nib
);
  // Each entry is {invalid, value}, indexed by (char - '0').
  function automatic logic [4:0] lut_entry(input int idx);
    if (idx < 10)      return {1'b0, 4'(idx)};
    else if (idx < 17) return 5'h10;
    else if (idx < 23) return {1'b0, 4'(idx - 7)};
    else               return 5'h10;
  endfunction

  logic [4:0] lut [LUT_N];

  for (genvar g = 0; g < LUT_N; g++) begin : g_lut
    assign lut[g] = lut_entry(g);
  end

  logic       in_rng;
  logic [4:0] idx;
  logic [4:0] ent;

  assign in_rng = (ch >= ASC_ZERO) && (ch <= ASC_BIGF);
  assign idx    = ch[4:0] - 5'h10;
  assign ent    = lut[idx];

  always_comb begin
    nib = ent[3:0];
    if (in_rng) begin
      kind = ent[4] ? CK_GAP : CK_HEX;
    end else begin
      case (ch)
        ASC_SPACE: kind = CK_SPACE;
        ASC_LF:    kind = CK_LF;
        ASC_CR:    kind = CK_CR;
        default:   kind = CK_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/hexrec_nibacc.sv
module hexrec_nibacc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         first,
  input  logic         shl,
  input  logic         bump,
  input  logic         drop,
  input  logic [3:0]   nib,
  output logic [W-1:0] val
);
  always_ff @(posedge clk) begin
    if (rst)        val <= '0;
    else if (first) val <= W'(nib);
    else if (shl)   val <= (val << 4) | W'(nib);
    else if (bump)  val <= val + W'(1);
    else if (drop)  val <= val - W'(1);
  end
endmodule

// File: rtl/hexrec_seq.sv
module hexrec_seq
  import hexrec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ch_valid,
  input  chkind_t           kind,
  input  logic [3:0]        nib,
  output logic              ch_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rec_done,
  output logic              err
);
  localparam int ADDR_DIGITS = ADDR_W / 4;
  localparam int DIG_W       = $clog2(ADDR_DIGITS + 1);

  pstate_t          st, st_n;
  logic [DIG_W-1:0] dig, dig_n;
  logic             take, bad;
  logic             a_first, a_shl, a_bump;
  logic             c_first, c_shl, c_drop;
  logic             b_first, b_shl;
  logic             wr_n, done_n, set_err;
  logic [ADDR_W-1:0] a_val;
  logic [CNT_W-1:0]  c_val;
  logic [DATA_W-1:0] b_val;

  hexrec_nibacc #(.W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .first(a_first), .shl(a_shl), .bump(a_bump),
    .drop(1'b0), .nib(nib), .val(a_val)
  );

  hexrec_nibacc #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .first(c_first), .shl(c_shl), .bump(1'b0),
    .drop(c_drop), .nib(nib), .val(c_val)
  );

  hexrec_nibacc #(.W(DATA_W)) u_byte (
    .clk(clk), .rst(rst), .first(b_first), .shl(b_shl), .bump(1'b0),
    .drop(1'b0), .nib(nib), .val(b_val)
  );

  assign ch_ready = (st != S_WR);
  assign take     = ch_valid && ch_ready;

  always_comb begin
    st_n    = st;
    dig_n   = dig;
    bad     = 1'b0;
    a_first = 1'b0; a_shl = 1'b0; a_bump = 1'b0;
    c_first = 1'b0; c_shl = 1'b0; c_drop = 1'b0;
    b_first = 1'b0; b_shl = 1'b0;
    wr_n    = 1'b0;
    done_n  = 1'b0;
    set_err = 1'b0;

    if (st == S_WR) begin
      a_bump = 1'b1;
      c_drop = 1'b1;
      st_n   = (c_val == CNT_W'(1)) ? S_DCMT : S_DHI;
    end else if (take && kind != CK_CR) begin
      case (st)
        S_ADDR: begin
          if (kind == CK_HEX) begin
            if (dig == DIG_W'(ADDR_DIGITS)) begin
              bad = 1'b1;
            end else begin
              a_first = (dig == '0);
              a_shl   = (dig != '0);
              dig_n   = dig + DIG_W'(1);
            end
          end else if (kind == CK_SPACE && dig == DIG_W'(ADDR_DIGITS)) begin
            st_n  = S_CNT;
            dig_n = '0;
          end else if (kind == CK_LF && dig == '0) begin
            st_n = S_ADDR;
          end else begin
            bad = 1'b1;
          end
        end
        S_CNT: begin
          if (kind == CK_HEX) begin
            c_first = (dig == '0);
            c_shl   = (dig != '0);
            dig_n   = DIG_W'(1);
          end else if (kind == CK_SPACE && dig != '0) begin
            st_n = S_HCMT;
          end else begin
            bad = 1'b1;
          end
        end
        S_HCMT: begin
          if (kind == CK_LF) begin
            dig_n = '0;
            if (c_val == '0) begin
              done_n = 1'b1;
              st_n   = S_ADDR;
            end else begin
              st_n = S_DHI;
            end
          end
        end
        S_DHI: begin
          if (kind == CK_HEX) begin
            b_first = 1'b1;
            st_n    = S_DLO;
          end else begin
            bad = 1'b1;
          end
        end
        S_DLO: begin
          if (kind == CK_HEX) begin
            b_shl = 1'b1;
            st_n  = S_DSP;
          end else begin
            bad = 1'b1;
          end
        end
        S_DSP: begin
          if (kind == CK_SPACE) begin
            wr_n = 1'b1;
            st_n = S_WR;
          end else begin
            bad = 1'b1;
          end
        end
        S_DCMT: begin
          if (kind == CK_LF) begin
            done_n = 1'b1;
            st_n   = S_ADDR;
            dig_n  = '0;
          end
        end
        S_DROP: begin
          if (kind == CK_LF) begin
            st_n  = S_ADDR;
            dig_n = '0;
          end
        end
        default: st_n = S_DROP;
      endcase

      if (bad) begin
        set_err = 1'b1;
        dig_n   = '0;
        st_n    = (kind == CK_LF) ? S_ADDR : S_DROP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_ADDR;
      dig      <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rec_done <= 1'b0;
      err      <= 1'b0;
    end else begin
      st       <= st_n;
      dig      <= dig_n;
      wr_en    <= wr_n;
      rec_done <= done_n;
      err      <= err | set_err;
      if (wr_n) begin
        wr_addr <= a_val;
        wr_data <= b_val;
      end
    end
  end

endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader
  import hexrec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ch_valid,
  input  logic [7:0]        ch_data,
  output logic              ch_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rec_done,
  output logic              err
);
  chkind_t    kind;
  logic [3:0] nib;

  hexrec_charclass #(.LUT_N(32)) u_cls (
    .ch(ch_data), .kind(kind), .nib(nib)
  );

  hexrec_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .ch_valid(ch_valid), .kind(kind), .nib(nib),
    .ch_ready(ch_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rec_done(rec_done), .err(err)
  );

endmodule

// File: rtl/hexrec_loader_chk.sv
module hexrec_loader_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ch_valid,
  input logic          ch_ready,
  input logic [7:0]    ch_data,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          rec_done,
  input logic          err
);
  logic          have_prev;
  logic [AW-1:0] last_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0;
      last_a    <= '0;
    end else if (ch_valid && ch_ready && ch_data == 8'h0A) begin
      have_prev <= 1'b0;
    end else if (wr_en) begin
      have_prev <= 1'b1;
      last_a    <= wr_addr;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!wr_en && !rec_done && !err && ch_ready));

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  a_r4_ready_low: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !ch_ready);

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && have_prev) |-> (wr_addr == last_a + AW'(1)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    rec_done |=> !rec_done);

  a_r5_done_no_write: assert property (@(posedge clk) disable iff (rst)
    rec_done |-> !wr_en);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  a_r10_err_on_char: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(ch_valid && ch_ready));

endmodule

bind hexrec_loader hexrec_loader_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_ready(ch_ready),
  .ch_data(ch_data), .wr_en(wr_en), .wr_addr(wr_addr),
  .rec_done(rec_done), .err(err)
);

// File: tb/sim_hexrec_loader.sv
module sim_hexrec_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ch_valid = 1'b0;
  logic [7:0]  ch_data = 8'h00;
  logic        ch_ready, wr_en, rec_done, err;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;

  int nchk = 0;
  int nerr = 0;
  int nw = 0;
  int nd = 0;
  logic [15:0] cap_a [64];
  logic [7:0]  cap_d [64];

  localparam logic [23:0] MAIN_EXP [7] = '{
    24'h12ACAE, 24'h12AD03, 24'h12AEB6, 24'h12AF91,
    24'h12B0C7, 24'h12B100, 24'h12B20C
  };

  always #5 clk = ~clk;

  hexrec_loader u0 (
    .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_data(ch_data),
    .ch_ready(ch_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rec_done(rec_done), .err(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Capture strobes mid-cycle; R4: ready must be low while the strobe is high.
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      cap_a[nw % 64] = wr_addr;
      cap_d[nw % 64] = wr_data;
      nw++;
      chk("R4 ready during write", {31'b0, ch_ready}, 32'h0);
    end
    if (!rst && rec_done) nd++;
  end

  task automatic send_ch(input logic [7:0] c);
    while (!ch_ready) @(negedge clk);
    ch_valid = 1'b1;
    ch_data  = c;
    @(negedge clk);
    ch_valid = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_ch(s[i]);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ch_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    int bw, bd;
    @(negedge clk);
    chk("R1 ready in reset", {31'b0, ch_ready}, 32'h1);
    do_reset();
    chk("R1 ready", {31'b0, ch_ready}, 32'h1);
    chk("R1 wr_en", {31'b0, wr_en}, 32'h0);
    chk("R1 rec_done", {31'b0, rec_done}, 32'h0);
    chk("R1 err", {31'b0, err}, 32'h0);

    // Main record: R2 header with comment, R3 ordering, R9 trailing comment
    bw = nw; bd = nd;
    send_str("12AC 7 (seven bytes)\nAE 03 B6 91 C7 00 0C (tail 11 22)\n");
    chk("R6 done after data LF", {31'b0, rec_done}, 32'h1);
    @(negedge clk);
    chk("R6 done one cycle", {31'b0, rec_done}, 32'h0);
    chk("R3 write count", nw - bw, 7);
    for (int i = 0; i < 7; i++) begin
      chk("R3 addr", {16'h0, cap_a[(bw + i) % 64]}, {16'h0, MAIN_EXP[i][23:8]});
      chk("R3 data", {24'h0, cap_d[(bw + i) % 64]}, {24'h0, MAIN_EXP[i][7:0]});
    end
    chk("R6 done count", nd - bd, 1);
    chk("R2 no err", {31'b0, err}, 32'h0);

    // R5 zero count
    bw = nw; bd = nd;
    send_str("0100 0 \n");
    chk("R5 done after header LF", {31'b0, rec_done}, 32'h1);
    settle();
    chk("R5 no writes", nw - bw, 0);
    chk("R5 one done", nd - bd, 1);

    // R7 wrap
    bw = nw;
    send_str("FFFE 3 \n11 22 33 \n");
    settle();
    chk("R7 count", nw - bw, 3);
    chk("R7 addr0", {16'h0, cap_a[bw % 64]}, 32'hFFFE);
    chk("R7 addr1", {16'h0, cap_a[(bw + 1) % 64]}, 32'hFFFF);
    chk("R7 addr2", {16'h0, cap_a[(bw + 2) % 64]}, 32'h0000);
    chk("R7 data2", {24'h0, cap_d[(bw + 2) % 64]}, 32'h33);
    chk("R7 no err", {31'b0, err}, 32'h0);

    // R8 CR anywhere
    bw = nw;
    send_str("02\01500 2 \015\n\015A\0151 B2 \015\n");
    settle();
    chk("R8 count", nw - bw, 2);
    chk("R8 addr0", {16'h0, cap_a[bw % 64]}, 32'h0200);
    chk("R8 data0", {24'h0, cap_d[bw % 64]}, 32'hA1);
    chk("R8 data1", {24'h0, cap_d[(bw + 1) % 64]}, 32'hB2);
    chk("R8 no err", {31'b0, err}, 32'h0);

    // R9 multi-digit count, trailing hex-looking comment ignored
    bw = nw;
    send_str("0300 002 junk\n5A 6B 7C 8D \n");
    settle();
    chk("R9 count", nw - bw, 2);
    chk("R9 data1", {24'h0, cap_d[(bw + 1) % 64]}, 32'h6B);

    // R13 blank lines
    bw = nw;
    send_str("\n\n0310 1 \n44 \n");
    settle();
    chk("R13 count", nw - bw, 1);
    chk("R13 addr", {16'h0, cap_a[bw % 64]}, 32'h0310);
    chk("R13 no err", {31'b0, err}, 32'h0);

    // R10 gap character, then R11 recovery with sticky err
    bw = nw; bd = nd;
    send_str("05:0 1 \n");
    settle();
    chk("R10 gap err", {31'b0, err}, 32'h1);
    chk("R10 no write", nw - bw, 0);
    chk("R10 no done", nd - bd, 0);
    send_str("0600 1 \nEE \n");
    settle();
    chk("R11 resume write", nw - bw, 1);
    chk("R11 resume addr", {16'h0, cap_a[bw % 64]}, 32'h0600);
    chk("R11 resume data", {24'h0, cap_d[bw % 64]}, 32'hEE);
    chk("R11 err sticky", {31'b0, err}, 32'h1);

    // R1 reset clears err; R10 lowercase rejected
    do_reset();
    chk("R1 err cleared", {31'b0, err}, 32'h0);
    bw = nw;
    send_str("07a0 1 \n");
    settle();
    chk("R10 lowercase err", {31'b0, err}, 32'h1);
    chk("R10 lowercase no write", nw - bw, 0);

    // R12 missing trailing space, then recovery
    do_reset();
    bw = nw; bd = nd;
    send_str("0800 1 \nAB\n");
    settle();
    chk("R12 err", {31'b0, err}, 32'h1);
    chk("R12 no write", nw - bw, 0);
    chk("R12 no done", nd - bd, 0);
    send_str("0810 1 \nCD \n");
    settle();
    chk("R12 recover write", nw - bw, 1);
    chk("R12 recover data", {24'h0, cap_d[bw % 64]}, 32'hCD);

    // R2 five-digit address is an error
    do_reset();
    bw = nw;
    send_str("12345 1 \n");
    settle();
    chk("R2 long address err", {31'b0, err}, 32'h1);
    chk("R2 long address no write", nw - bw, 0);

    // R1 reset mid-record abandons it
    do_reset();
    send_str("0900 2 \n11 ");
    settle();
    do_reset();
    bw = nw;
    send_str("0A00 1 \n22 \n");
    settle();
    chk("R1 mid-record count", nw - bw, 1);
    chk("R1 mid-record addr", {16'h0, cap_a[bw % 64]}, 32'h0A00);
    chk("R1 mid-record err", {31'b0, err}, 32'h0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule